// File: doc/BRIEF.md
# Laundry Program Sequencer

This block drives one complete laundry program. The program has four phases: a hot-water wash, a spin, a cold-water rinse and a second spin. Three single-cycle event pulses move it along. A start request begins the program. A "vessel full" event ends each fill and an "vessel empty" event ends each drain. The block drives four actuator lines: drum motor, hot valve, cold valve and drain pump.

All timed phases share one down counter. The counter counts in minutes. It advances only on cycles where a one-cycle minute strobe is high, and that strobe runs on the system clock. The wash length comes from an operator dial. The first spin, the rinse and the second spin have fixed lengths of 7, 10 and 8 minutes, set as parameters.

Each timed phase spends exactly one cycle in a load step, and all actuators are low in that cycle. The counter's zero flag is examined only after that step. A zero count left over from the previous phase therefore cannot cut a phase short. The event pulses and the strobe are plain control pins with no handshake. A pulse that arrives while the sequencer is not waiting for that event is dropped.

Top module: `wash_sequencer`

## Requirements
- R1: A synchronous `rst` drives all four actuator outputs low in the cycle after it is sampled. It returns the sequencer to idle and clears the counter, and the sequencer stays idle until a new start pulse.
- R2: In idle, all outputs stay low. A `start_pulse` sampled in idle raises `hot_valve`, and only `hot_valve`, in the next cycle.
- R3: `hot_valve` stays high until `full_pulse` is sampled. Next comes one cycle with all outputs low. Then `motor_turn` alone is high. Excluding its final cycle, the stretch with `motor_turn` high contains exactly `dial_minutes` cycles with `minute_tick` high. A dial of 0 gives a single cycle of turning.
- R4: After the wash, `drain_valve` alone is high until `empty_pulse` is sampled. One further cycle follows with only the drain high. Then drain and motor are high together, for a stretch containing 7 tick cycles excluding its last cycle.
- R5: After the first spin, `cold_valve` alone is high until `full_pulse`. One cycle with all outputs low follows. Then `motor_turn` alone is high for a stretch containing 10 tick cycles excluding its last.
- R6: After the rinse, the second drain and spin follow the R4 pattern with a length of 8 tick cycles. After that, all outputs return low and stay low.
- R7: A `start_pulse` sampled while a program is running has no effect. A `full_pulse` or `empty_pulse` sampled outside the phase that waits for it has no effect. Here "no effect" means every phase length and output pattern is unchanged.
- R8: `hot_valve` and `cold_valve` are never high together. Neither valve is high while `drain_valve` or `motor_turn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_pulse | input | 1 | One-cycle request to begin a program |
| full_pulse | input | 1 | One-cycle event: vessel filled |
| empty_pulse | input | 1 | One-cycle event: vessel drained |
| minute_tick | input | 1 | One-cycle strobe, once per minute |
| dial_minutes | input | DIAL_W (8) | Wash length in minutes, taken in the wash load cycle |
| motor_turn | output | 1 | Drum motor on |
| hot_valve | output | 1 | Hot water inlet open |
| cold_valve | output | 1 | Cold water inlet open |
| drain_valve | output | 1 | Drain pump on |

## Verification
The actuator outputs are decoded directly from the phase register. A wrong or skipped phase therefore shows in the very next cycle as a wrong actuator combination or a missing load cycle. A fault in the counter's load value, or in how it decrements, shows up when the motor stops. That happens at the end of the affected phase, as a wrong number of minute strobes during the turning stretch. The bench compresses the output trace into runs of identical actuator codes. It compares each run's code, length and strobe count with values it works out from the dial setting, the strobe period and its own response delays. It does this across a sweep of dial values, several strobe periods, and stray pulses injected during the run.

// File: rtl/wash_pkg.sv
package wash_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOT_FILL,
    ST_WASH_LOAD,
    ST_WASH_RUN,
    ST_DRAIN_A,
    ST_SPIN_A_LOAD,
    ST_SPIN_A_RUN,
    ST_COLD_FILL,
    ST_RINSE_LOAD,
    ST_RINSE_RUN,
    ST_DRAIN_B,
    ST_SPIN_B_LOAD,
    ST_SPIN_B_RUN
  } phase_t;

  typedef enum logic [1:0] {
    SRC_DIAL,
    SRC_SPIN_A,
    SRC_RINSE,
    SRC_SPIN_B
  } load_src_t;

  typedef struct packed {
    logic turn;
    logic hot;
    logic cold;
    logic drain;
  } actuators_t;

endpackage

// File: rtl/wash_phase_fsm.sv
module wash_phase_fsm
  import wash_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   full,
  input  logic   empty,
  input  logic   cnt_zero,
  output phase_t phase
);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE:        if (start)    phase_d = ST_HOT_FILL;
      ST_HOT_FILL:    if (full)     phase_d = ST_WASH_LOAD;
      ST_WASH_LOAD:                 phase_d = ST_WASH_RUN;
      ST_WASH_RUN:    if (cnt_zero) phase_d = ST_DRAIN_A;
      ST_DRAIN_A:     if (empty)    phase_d = ST_SPIN_A_LOAD;
      ST_SPIN_A_LOAD:               phase_d = ST_SPIN_A_RUN;
      ST_SPIN_A_RUN:  if (cnt_zero) phase_d = ST_COLD_FILL;
      ST_COLD_FILL:   if (full)     phase_d = ST_RINSE_LOAD;
      ST_RINSE_LOAD:                phase_d = ST_RINSE_RUN;
      ST_RINSE_RUN:   if (cnt_zero) phase_d = ST_DRAIN_B;
      ST_DRAIN_B:     if (empty)    phase_d = ST_SPIN_B_LOAD;
      ST_SPIN_B_LOAD:               phase_d = ST_SPIN_B_RUN;
      ST_SPIN_B_RUN:  if (cnt_zero) phase_d = ST_IDLE;
      default:                      phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= ST_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == ST_IDLE && start) |=> (phase_q == ST_HOT_FILL));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != ST_IDLE && start) |=>
      (phase_q != ST_HOT_FILL || $past(phase_q) == ST_HOT_FILL));

endmodule

// File: rtl/wash_phase_decode.sv
module wash_phase_decode
  import wash_pkg::*;
(
  input  phase_t     phase,
  output actuators_t act,
  output logic       cnt_clr,
  output logic       cnt_load,
  output logic       cnt_dec,
  output load_src_t  load_src
);

  always_comb begin
    act      = '0;
    cnt_clr  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    load_src = SRC_DIAL;
    unique case (phase)
      ST_IDLE:        cnt_clr = 1'b1;
      ST_HOT_FILL:    act.hot = 1'b1;
      ST_WASH_LOAD: begin
        cnt_load = 1'b1;
        load_src = SRC_DIAL;
      end
      ST_WASH_RUN: begin
        cnt_dec  = 1'b1;
        act.turn = 1'b1;
      end
      ST_DRAIN_A:     act.drain = 1'b1;
      ST_SPIN_A_LOAD: begin
        act.drain = 1'b1;
        cnt_load  = 1'b1;
        load_src  = SRC_SPIN_A;
      end
      ST_SPIN_A_RUN: begin
        act.drain = 1'b1;
        act.turn  = 1'b1;
        cnt_dec   = 1'b1;
      end
      ST_COLD_FILL:   act.cold = 1'b1;
      ST_RINSE_LOAD: begin
        cnt_load = 1'b1;
        load_src = SRC_RINSE;
      end
      ST_RINSE_RUN: begin
        cnt_dec  = 1'b1;
        act.turn = 1'b1;
      end
      ST_DRAIN_B:     act.drain = 1'b1;
      ST_SPIN_B_LOAD: begin
        act.drain = 1'b1;
        cnt_load  = 1'b1;
        load_src  = SRC_SPIN_B;
      end
      ST_SPIN_B_RUN: begin
        act.drain = 1'b1;
        act.turn  = 1'b1;
        cnt_dec   = 1'b1;
      end
      default:        cnt_clr = 1'b1;
    endcase
  end

endmodule

// File: rtl/wash_load_mux.sv
module wash_load_mux
  import wash_pkg::*;
#(
  parameter int W         = 8,
  parameter int SPIN_A_MIN = 7,
  parameter int RINSE_MIN  = 10,
  parameter int SPIN_B_MIN = 8
) (
  input  load_src_t      sel,
  input  logic [W-1:0]   dial,
  output logic [W-1:0]   value
);

  localparam logic [W-1:0] SPIN_A_VAL = W'(SPIN_A_MIN);
  localparam logic [W-1:0] RINSE_VAL  = W'(RINSE_MIN);
  localparam logic [W-1:0] SPIN_B_VAL = W'(SPIN_B_MIN);

  always_comb begin
    unique case (sel)
      SRC_DIAL:   value = dial;
      SRC_SPIN_A: value = SPIN_A_VAL;
      SRC_RINSE:  value = RINSE_VAL;
      SRC_SPIN_B: value = SPIN_B_VAL;
      default:    value = dial;
    endcase
  end

endmodule

// File: rtl/minute_down_counter.sv
module minute_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         tick,
  output logic         zero
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (clr)                               count_q <= '0;
    else if (load)                         count_q <= load_val;
    else if (dec && tick && count_q != '0) count_q <= count_q - 1'b1;
  end

  assign zero = (count_q == '0);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (clr)
    load |=> (count_q == $past(load_val)));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && dec && tick && !zero) |=> (count_q == $past(count_q) - 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && !(dec && tick)) |=> $stable(count_q));

  // R3
  floor_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && zero) |=> zero);

endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer
  import wash_pkg::*;
#(
  parameter int DIAL_W     = 8,
  parameter int SPIN_A_MIN = 7,
  parameter int RINSE_MIN  = 10,
  parameter int SPIN_B_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_pulse,
  input  logic              full_pulse,
  input  logic              empty_pulse,
  input  logic              minute_tick,
  input  logic [DIAL_W-1:0] dial_minutes,
  output logic              motor_turn,
  output logic              hot_valve,
  output logic              cold_valve,
  output logic              drain_valve
);

  phase_t              phase;
  actuators_t          act;
  logic                dec_clr, cnt_load, cnt_dec, cnt_zero;
  load_src_t           load_src;
  logic [DIAL_W-1:0]   load_val;

  wash_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start_pulse),
    .full     (full_pulse),
    .empty    (empty_pulse),
    .cnt_zero (cnt_zero),
    .phase    (phase)
  );

  wash_phase_decode u_decode (
    .phase    (phase),
    .act      (act),
    .cnt_clr  (dec_clr),
    .cnt_load (cnt_load),
    .cnt_dec  (cnt_dec),
    .load_src (load_src)
  );

  wash_load_mux #(
    .W          (DIAL_W),
    .SPIN_A_MIN (SPIN_A_MIN),
    .RINSE_MIN  (RINSE_MIN),
    .SPIN_B_MIN (SPIN_B_MIN)
  ) u_mux (
    .sel   (load_src),
    .dial  (dial_minutes),
    .value (load_val)
  );

  minute_down_counter #(.W(DIAL_W)) u_cnt (
    .clk      (clk),
    .clr      (rst | dec_clr),
    .load     (cnt_load),
    .load_val (load_val),
    .dec      (cnt_dec),
    .tick     (minute_tick),
    .zero     (cnt_zero)
  );

  assign motor_turn  = act.turn;
  assign hot_valve   = act.hot;
  assign cold_valve  = act.cold;
  assign drain_valve = act.drain;

  // R8
  valve_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hot_valve && cold_valve) && !((hot_valve || cold_valve) && (drain_valve || motor_turn)));

  // R6
  program_end_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_SPIN_B_RUN && cnt_zero) |=>
      (!motor_turn && !hot_valve && !cold_valve && !drain_valve));

  // R4
  spin_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_DRAIN_A && empty_pulse) |=> (drain_valve && !motor_turn));

endmodule

// File: tb/test_wash_sequencer.sv
module test_wash_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, full = 1'b0, empty = 1'b0, tick = 1'b0;
  logic [7:0] dial = '0;
  logic       turn, hot, cold, drain;

  int tests = 0, fails = 0, cyc = 0, period = 1, excl_bad = 0;
  logic [3:0] obs;
  int tnext;
  int rc[0:15], rl[0:15], rt[0:15];

  always #4 clk = ~clk;

  wash_sequencer i_wash_sequencer (
    .clk(clk), .rst(rst), .start_pulse(start), .full_pulse(full),
    .empty_pulse(empty), .minute_tick(tick), .dial_minutes(dial),
    .motor_turn(turn), .hot_valve(hot), .cold_valve(cold), .drain_valve(drain)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // code: bit3 turn, bit2 hot, bit1 cold, bit0 drain
  task automatic cycle();
    @(posedge clk); #1;
    start = 1'b0; full = 1'b0; empty = 1'b0;
    #1;
    obs = {turn, hot, cold, drain};
    if ((hot && cold) || ((hot || cold) && (drain || turn))) excl_bad++;
    cyc++;
    tick = ((cyc % period) == 0);
    tnext = int'(tick);
  endtask

  function automatic int exp_code(input int i);
    case (i)
      0: return 4;  1: return 0;  2: return 8;  3: return 1;  4: return 9;
      5: return 2;  6: return 0;  7: return 8;  8: return 1;  9: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic string run_req(input int i);
    if (i == 0) return "R2";
    if (i <= 2) return "R3";
    if (i <= 4) return "R4";
    if (i <= 7) return "R5";
    return "R6";
  endfunction

  task automatic run_prog(input int dv, input int per, input int f, input int d, input bit inj);
    int n, fc, dc, pt, bad0;
    string rq;
    n = 0; fc = 0; dc = 0; pt = 0; bad0 = excl_bad;
    dial = 8'(dv); period = per;
    start = 1'b1;
    for (int lim = 0; lim < 4000 && n < 11; lim++) begin
      cycle();
      if (n == 0 || int'(obs) != rc[n-1]) begin
        if (n > 0) rt[n-1] -= pt;
        rc[n] = int'(obs); rl[n] = 1; rt[n] = tnext; n++;
      end else begin
        rl[n-1]++; rt[n-1] += tnext;
      end
      pt = tnext;
      if (obs == 4'd4 || obs == 4'd2) begin
        fc++;
        if (fc == f) begin full = 1'b1; fc = 0; end
      end else fc = 0;
      if (obs == 4'd1) begin
        dc++;
        if (dc == d) begin empty = 1'b1; dc = 0; end
      end else dc = 0;
      if (inj && obs[3] && (cyc % 5 == 0)) begin
        start = 1'b1; full = 1'b1; empty = 1'b1;
      end
    end
    rq = inj ? "R7" : "";
    chk(n == 11, "R6", "run count", n, 11);
    for (int i = 0; i < n && i < 11; i++)
      chk(rc[i] == exp_code(i), {run_req(i), rq}, $sformatf("dial %0d run %0d code", dv, i), rc[i], exp_code(i));
    if (n == 11) begin
      chk(rl[0] == f, "R3", "hot fill length", rl[0], f);
      chk(rl[1] == 1, "R3", "wash load cycle", rl[1], 1);
      chk(rt[2] == dv, {"R3", rq}, $sformatf("wash ticks dial %0d per %0d", dv, per), rt[2], dv);
      chk(rl[3] == d + 1, "R4", "first drain length", rl[3], d + 1);
      chk(rt[4] == 7, {"R4", rq}, "first spin ticks", rt[4], 7);
      chk(rl[5] == f, "R5", "cold fill length", rl[5], f);
      chk(rl[6] == 1, "R5", "rinse load cycle", rl[6], 1);
      chk(rt[7] == 10, {"R5", rq}, "rinse ticks", rt[7], 10);
      chk(rl[8] == d + 1, "R6", "second drain length", rl[8], d + 1);
      chk(rt[9] == 8, {"R6", rq}, "second spin ticks", rt[9], 8);
      if (per == 1) begin
        chk(rl[2] == dv + 1, "R3", "wash turn length", rl[2], dv + 1);
        chk(rl[9] == 9, "R6", "second spin length", rl[9], 9);
      end
    end
    for (int k = 0; k < 3; k++) begin
      cycle();
      chk(obs == 4'd0, "R6", "idle after program", int'(obs), 0);
    end
    chk(excl_bad == bad0, "R8", "valve exclusivity violations", excl_bad - bad0, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cycle(); cycle();
    chk(obs == 4'd0, "R1", "outputs under reset", int'(obs), 0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cycle();
      chk(obs == 4'd0, "R2", "idle without start", int'(obs), 0);
    end
    full = 1'b1; cycle(); empty = 1'b1; cycle(); cycle();
    chk(obs == 4'd0, "R7", "full/empty in idle", int'(obs), 0);

    for (int dv = 0; dv < 32; dv++) run_prog(dv, 1, 1 + dv % 4, 2 + dv % 3, 1'b0);
    for (int dv = 250; dv < 256; dv++) run_prog(dv, 1, 2, 3, 1'b0);
    run_prog(0, 3, 2, 2, 1'b0);
    run_prog(1, 3, 3, 4, 1'b0);
    run_prog(9, 4, 1, 2, 1'b0);
    run_prog(40, 3, 2, 5, 1'b0);
    run_prog(200, 7, 2, 2, 1'b0);
    run_prog(12, 1, 2, 3, 1'b1);
    run_prog(23, 2, 3, 2, 1'b1);

    // reset in the middle of the wash
    period = 1; dial = 8'd50;
    start = 1'b1; cycle();
    full = 1'b1; cycle();
    cycle(); cycle();
    chk(obs == 4'd8, "R3", "turning before mid reset", int'(obs), 8);
    rst = 1'b1; cycle();
    chk(obs == 4'd0, "R1", "outputs after mid reset", int'(obs), 0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cycle();
      chk(obs == 4'd0, "R1", "idle after mid reset", int'(obs), 0);
    end
    run_prog(5, 1, 2, 2, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule